// File: doc/BRIEF.md
# Dual-Role SPI Byte Controller

This block moves one byte at a time over a four-wire serial link and can act on either end of it. A control bit picks the role. As master it makes the serial clock from the system clock, drives the outgoing data line and samples the incoming one. As slave it takes clock and data from outside and answers only while its active-low select input is low. Every transfer is full duplex. The byte loaded by the host goes out while the byte from the far side comes in. When the byte is done, the two ends have swapped contents.

The host reaches the block through three small registers, picked by a 2-bit address:

| Address | Register |
|---|---|
| 0 | Control |
| 1 | Status |
| 2 | Data |

In master mode a write to the data register starts the clock generator, which stops by itself after one byte. Completion sets a flag, and that flag can raise an interrupt. A data write that arrives while a byte is in flight is refused and sets a collision flag. Both flags clear when the host reads status and then accesses the data register.

The serial timing is mode 0. The clock idles low, data is sampled on the rising edge and changed on the falling edge. The master rate is one of four divisions of the system clock. The bit order can be set to least or most significant bit first.

Top module: `spi_dual_role`

## Requirements
- R1: After reset the control, status and data registers read 0, `irq_o`, `sck_o` and `miso_oe` are low, and the block is in neither role.
- R2: With control bits enable (bit 0) and master (bit 1) set, a data write (address 2) that is not refused starts a transfer. `sck_o` idles low, and for a divide ratio D it rises first D/2 clocks after the write edge. It toggles every D/2 clocks and returns low for good 8·D clocks after the write edge.
- R3: Control bits [5:4] select the master divide ratio D: 0 gives 4, 1 gives 16, 2 gives 64 and 3 gives 128 system clocks per serial clock period.
- R4: Each transfer is full duplex. The far side receives the byte written, and afterwards the data register reads the byte received. Data is sampled on the rising serial clock edge and changed on the falling edge.
- R5: Control bit 2 selects the bit order: 0 sends and receives the most significant bit first, 1 the least significant bit first. This holds in both roles.
- R6: Status bit 0 (done) sets when the eighth bit completes. `irq_o` is high exactly while done is set and control bit 3 (interrupt enable) is set.
- R7: A data write while a byte is in flight sets status bit 1 (collision). The write is ignored, and the byte in flight and its result are unchanged.
- R8: A status read while a flag is set, followed by any data register read or write, clears both flags. A data access without that status read leaves them set.
- R9: In slave mode (enable set, master clear) the block shifts, and drives `miso_oe` high, only while `ss_n_i` is low. Serial clock edges with `ss_n_i` high have no effect.
- R10: In slave mode, raising `ss_n_i` partway through a byte clears the bit count and drops the partial byte. The data register again holds the byte loaded before the transfer, and the done flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe (reads have side effects on flags) |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wdata | input | DW | Host write data |
| rdata | output | DW | Host read data for the selected register |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock out, master mode |
| sck_i | input | 1 | Serial clock in, slave mode |
| mosi_o | output | 1 | Master data out |
| mosi_i | input | 1 | Slave data in |
| miso_i | input | 1 | Master data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data out enable, high while selected |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The assertions assume the control register is not rewritten while a byte is in flight. In slave mode they also assume each serial clock level outlasts the input synchronizer by a few system clocks. Under the same assumption, the far master changes data only after a falling edge. The bench honours these assumptions: it writes control only between transfers, and it drives each slave-mode clock phase for eight system clocks. Its model of the far slave changes `miso_i` only after it sees `sck_o` fall. The master clock is compared with the model on every clock during each transfer.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // control register, bit 0 first: enable, master, lsb_first, irq_en, rate[1:0]
    typedef struct packed {
        logic [1:0] rate;
        logic       irq_en;
        logic       lsb_first;
        logic       master;
        logic       enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // half of the serial clock period in system clocks
    function automatic int unsigned half_period(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2;
            2'd1:    return 8;
            2'd2:    return 32;
            default: return 64;
        endcase
    endfunction

endpackage

// File: rtl/spi_master_clk.sv
module spi_master_clk #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stop,
    input  logic [1:0] rate,
    output logic       active,
    output logic       sck,
    output logic       lead,
    output logic       trail
);
    typedef struct packed {
        logic             active;
        logic             sck;
        logic [CNT_W-1:0] cnt;
    } gen_t;

    gen_t             st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             tick;

    always_comb begin
        limit = CNT_W'(spi_dr_pkg::half_period(rate) - 1);
        tick  = st_q.active && (st_q.cnt == limit);
        lead  = tick && !st_q.sck;
        trail = tick && st_q.sck;
        st_d  = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.sck    = 1'b0;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (tick) begin
                st_d.cnt = '0;
                st_d.sck = !st_q.sck;
                if (trail && stop) begin
                    st_d.active = 1'b0;
                    st_d.sck    = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign sck    = st_q.sck;
endmodule

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic mosi_i,
    input  logic ss_n_i,
    output logic sck_s,
    output logic mosi_s,
    output logic ss_n_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic ss_rise
);
    localparam logic [2:0] IDLE = 3'b100; // {ss_n, mosi, sck}

    logic [2:0] stage_d [STAGES];
    logic [2:0] stage_q [STAGES];
    logic [1:0] prev_d, prev_q;           // {ss_n, sck} one clock older

    always_comb begin
        stage_d[0] = {ss_n_i, mosi_i, sck_i};
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
        prev_d = {stage_q[STAGES-1][2], stage_q[STAGES-1][0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= IDLE;
            prev_q <= 2'b10;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
            prev_q <= prev_d;
        end
    end

    assign sck_s    = stage_q[STAGES-1][0];
    assign mosi_s   = stage_q[STAGES-1][1];
    assign ss_n_s   = stage_q[STAGES-1][2];
    assign sck_rise = sck_s && !prev_q[0];
    assign sck_fall = !sck_s && prev_q[0];
    assign ss_rise  = ss_n_s && !prev_q[1];
endmodule

// File: rtl/spi_dual_role.sv
module spi_dual_role #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq_o,
    output logic          sck_o,
    input  logic          sck_i,
    output logic          mosi_o,
    input  logic          mosi_i,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          ss_n_i
);
    import spi_dr_pkg::*;

    localparam int          CW   = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] sr;      // shift register, shared by both roles
        logic [DW-1:0] hold;    // byte restored on a slave abort
        logic          rx_bit;  // bit taken on the leading edge
        logic [CW-1:0] bitcnt;
        logic          s_busy;
        logic          done;
        logic          wcol;
        logic          armed;   // status was read while a flag was set
    } core_t;

    core_t st_d, st_q;

    logic m_active, m_sck, m_lead, m_trail;
    logic sck_s, mosi_s, ss_n_s, sck_rise, sck_fall, ss_rise;
    logic master_mode, slave_mode, selected, busy, out_bit;
    logic data_wr, data_acc, start, last;
    logic [CW-1:0] bitcnt_w;
    logic done_w, wcol_w, s_busy_w;

    function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] v,
                                               input logic b, input logic lsb);
        return lsb ? {b, v[DW-1:1]} : {v[DW-2:0], b};
    endfunction

    spi_master_clk #(.CNT_W(DIV_W)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .stop   (last),
        .rate   (st_q.ctrl.rate),
        .active (m_active),
        .sck    (m_sck),
        .lead   (m_lead),
        .trail  (m_trail)
    );

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_i),
        .mosi_i   (mosi_i),
        .ss_n_i   (ss_n_i),
        .sck_s    (sck_s),
        .mosi_s   (mosi_s),
        .ss_n_s   (ss_n_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .ss_rise  (ss_rise)
    );

    always_comb begin
        master_mode = st_q.ctrl.enable && st_q.ctrl.master;
        slave_mode  = st_q.ctrl.enable && !st_q.ctrl.master;
        selected    = slave_mode && !ss_n_s;
        busy        = (master_mode && m_active) || (slave_mode && st_q.s_busy);
        out_bit     = st_q.ctrl.lsb_first ? st_q.sr[0] : st_q.sr[DW-1];
        data_wr     = wr_en && (addr == ADDR_DATA);
        data_acc    = (wr_en || rd_en) && (addr == ADDR_DATA);
        start       = data_wr && !busy && master_mode;
        last        = (st_q.bitcnt == LAST);

        st_d = st_q;
        if (wr_en && addr == ADDR_CTRL) st_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
        if (rd_en && addr == ADDR_STAT && (st_q.done || st_q.wcol)) st_d.armed = 1'b1;
        if (data_acc && st_q.armed) begin
            st_d.done  = 1'b0;
            st_d.wcol  = 1'b0;
            st_d.armed = 1'b0;
        end
        if (data_wr) begin
            if (busy) begin
                st_d.wcol = 1'b1;
            end else begin
                st_d.sr     = wdata;
                st_d.hold   = wdata;
                st_d.bitcnt = '0;
            end
        end

        if (master_mode) begin
            if (m_lead) st_d.rx_bit = miso_i;
            if (m_trail) begin
                st_d.sr     = shift_in(st_q.sr, st_q.rx_bit, st_q.ctrl.lsb_first);
                st_d.bitcnt = st_q.bitcnt + CW'(1);
                if (last) begin
                    st_d.done   = 1'b1;
                    st_d.hold   = st_d.sr;
                    st_d.bitcnt = '0;
                end
            end
        end

        if (slave_mode) begin
            if (ss_rise) begin
                st_d.bitcnt = '0;
                st_d.s_busy = 1'b0;
                st_d.sr     = st_q.hold;
            end else if (selected && sck_rise) begin
                st_d.rx_bit = mosi_s;
                st_d.s_busy = 1'b1;
            end else if (selected && sck_fall && st_q.s_busy) begin
                st_d.sr     = shift_in(st_q.sr, st_q.rx_bit, st_q.ctrl.lsb_first);
                st_d.bitcnt = st_q.bitcnt + CW'(1);
                if (last) begin
                    st_d.done   = 1'b1;
                    st_d.s_busy = 1'b0;
                    st_d.hold   = st_d.sr;
                    st_d.bitcnt = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = DW'(st_q.ctrl);
            ADDR_STAT: rdata = DW'({st_q.wcol, st_q.done});
            ADDR_DATA: rdata = st_q.sr;
            default:   rdata = '0;
        endcase
    end

    assign sck_o    = master_mode && m_sck;
    assign mosi_o   = master_mode && out_bit;
    assign miso_o   = selected && out_bit;
    assign miso_oe  = selected;
    assign irq_o    = st_q.done && st_q.ctrl.irq_en;
    assign bitcnt_w = st_q.bitcnt;
    assign done_w   = st_q.done;
    assign wcol_w   = st_q.wcol;
    assign s_busy_w = st_q.s_busy;
endmodule

// File: rtl/spi_dual_role_chk.sv
module spi_dual_role_chk #(
    parameter int DW = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [1:0]            addr,
    input logic                  sck_o,
    input logic                  irq_o,
    input logic                  miso_oe,
    input logic                  m_active,
    input logic                  busy,
    input logic                  slave_mode,
    input logic                  ss_n_s,
    input logic                  ss_rise,
    input logic                  done_q,
    input logic                  wcol_q,
    input logic                  s_busy,
    input logic [$clog2(DW)-1:0] bitcnt_q
);
    localparam logic [$clog2(DW)-1:0] LAST = ($clog2(DW))'(DW - 1);

    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m_active |-> !sck_o);

    // R2
    gen_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m_active) |-> (bitcnt_q == '0) && done_q);

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(bitcnt_q) == LAST);

    // R6
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> done_q);

    // R7
    wcol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol_q) |-> $past(wr_en && addr == 2'd2 && busy));

    // R9
    miso_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !ss_n_s);

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_rise && slave_mode) |=> (bitcnt_q == '0) && !s_busy);
endmodule

bind spi_dual_role spi_dual_role_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .sck_o      (sck_o),
    .irq_o      (irq_o),
    .miso_oe    (miso_oe),
    .m_active   (m_active),
    .busy       (busy),
    .slave_mode (slave_mode),
    .ss_n_s     (ss_n_s),
    .ss_rise    (ss_rise),
    .done_q     (done_w),
    .wcol_q     (wcol_w),
    .s_busy     (s_busy_w),
    .bitcnt_q   (bitcnt_w)
);

// File: tb/spi_dual_role_tb.sv
`timescale 1ns/1ps
module spi_dual_role_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0, rd_en = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       irq_o, sck_o, mosi_o, miso_o, miso_oe;
    logic       sck_i = 0, mosi_i = 0, miso_i = 0, ss_n_i = 1;

    int n_checks = 0;
    int n_errors = 0;

    // far-slave model used in master mode
    logic [7:0] sl_tx = 0, sl_rx = 0;
    logic       sl_lsb = 0, sl_prev = 0;
    int         sl_idx = 0;

    always #2.5 clk = ~clk;

    spi_dual_role u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .sck_o(sck_o), .sck_i(sck_i),
        .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_i(miso_i), .miso_o(miso_o),
        .miso_oe(miso_oe), .ss_n_i(ss_n_i)
    );

    function automatic int bitpos(input int i, input logic lsb);
        return lsb ? i : 7 - i;
    endfunction

    always @(negedge clk) begin
        if (sck_o && !sl_prev && sl_idx < 8) sl_rx[bitpos(sl_idx, sl_lsb)] = mosi_o;
        if (!sck_o && sl_prev) sl_idx++;
        sl_prev = sck_o;
        miso_i  = (sl_idx < 8) ? sl_tx[bitpos(sl_idx, sl_lsb)] : 1'b0;
    end

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic clear_flags();
        logic [7:0] t;
        host_read(2'd1, t);
        host_read(2'd2, t);
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rxb,
                               input int half, input logic lsb, input logic exp_irq);
        int bad = 0;
        int first_bad = -1;
        logic expv;
        logic [7:0] got;
        sl_tx = rxb; sl_idx = 0; sl_rx = 0; sl_lsb = lsb;
        host_write(2'd2, tx);
        for (int k = 1; k <= 16 * half; k++) begin
            @(negedge clk);
            expv = (k < 16 * half) ? (((k / half) % 2) == 1) : 1'b0;
            n_checks++;
            if (sck_o !== expv) begin
                bad++;
                if (first_bad < 0) first_bad = k;
            end
        end
        if (bad != 0) begin
            n_errors += bad;
            $display("FAIL R2/R3 sck profile: actual=%0d bad cycles from %0d expected=0",
                     bad, first_bad);
        end
        check_eq("R4 far side got written byte", sl_rx, tx);
        host_read(2'd2, got);
        check_eq("R4 data holds received byte", got, rxb);
        check_eq("R6 irq after done", irq_o, exp_irq);
    endtask

    task automatic slave_xfer(input logic [7:0] mb, input logic lsb, input int nbits,
                              output logic [7:0] cap);
        cap = 0;
        @(negedge clk);
        ss_n_i = 0;
        repeat (8) @(negedge clk);
        check_eq("R9 miso_oe while selected", miso_oe, 1);
        for (int i = 0; i < nbits; i++) begin
            mosi_i = mb[bitpos(i, lsb)];
            repeat (8) @(negedge clk);
            cap[bitpos(i, lsb)] = miso_o;
            sck_i = 1;
            repeat (8) @(negedge clk);
            sck_i = 0;
        end
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] v, cap;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        host_read(2'd0, v); check_eq("R1 ctrl reset", v, 0);
        host_read(2'd1, v); check_eq("R1 status reset", v, 0);
        host_read(2'd2, v); check_eq("R1 data reset", v, 0);
        check_eq("R1 irq reset", irq_o, 0);
        check_eq("R1 sck reset", sck_o, 0);
        check_eq("R1 miso_oe reset", miso_oe, 0);

        // R2 R3 R4 R5: master, MSB first, divide 4, irq enabled
        host_write(2'd0, 8'h0B);
        master_xfer(8'hA5, 8'h3C, 2, 1'b0, 1'b1);

        // R8 data access without status read keeps flags
        host_read(2'd2, v);
        host_read(2'd1, v); check_eq("R8 flags kept without status read", v, 8'h01);
        host_read(2'd2, v);
        host_read(2'd1, v); check_eq("R8 flags cleared", v, 0);
        check_eq("R6 irq low after clear", irq_o, 0);

        // R5 LSB first, R3 divide 16
        host_write(2'd0, 8'h1F);
        master_xfer(8'h1E, 8'hC4, 8, 1'b1, 1'b1);
        clear_flags();

        // R3 divide 64, R6 irq disabled
        host_write(2'd0, 8'h23);
        master_xfer(8'h5A, 8'h99, 32, 1'b0, 1'b0);
        host_read(2'd1, v); check_eq("R6 done without irq", v, 8'h01);
        host_read(2'd2, v);

        // R3 divide 128
        host_write(2'd0, 8'h33);
        master_xfer(8'h07, 8'hE0, 64, 1'b0, 1'b0);
        clear_flags();

        // R7 collision
        host_write(2'd0, 8'h03);
        sl_tx = 8'h12; sl_idx = 0; sl_rx = 0; sl_lsb = 0;
        host_write(2'd2, 8'h6B);
        repeat (3) @(negedge clk);
        host_write(2'd2, 8'hFF);
        repeat (40) @(negedge clk);
        host_read(2'd1, v); check_eq("R7 collision and done", v, 8'h03);
        check_eq("R7 byte in flight unchanged", sl_rx, 8'h6B);
        host_read(2'd2, v); check_eq("R7 result unchanged", v, 8'h12);
        host_read(2'd1, v); check_eq("R8 collision cleared", v, 0);

        // R9 slave mode, deselected clocks ignored
        host_write(2'd0, 8'h01);
        host_write(2'd2, 8'hC3);
        for (int p = 0; p < 2; p++) begin
            mosi_i = 1; sck_i = 1;
            repeat (8) @(negedge clk);
            sck_i = 0;
            repeat (8) @(negedge clk);
        end
        check_eq("R9 miso_oe low while deselected", miso_oe, 0);
        host_read(2'd1, v); check_eq("R9 no done while deselected", v, 0);
        host_read(2'd2, v); check_eq("R9 data untouched while deselected", v, 8'hC3);

        // R4 R9 slave full byte, MSB first
        slave_xfer(8'h96, 1'b0, 8, cap);
        check_eq("R4 slave sent loaded byte", cap, 8'hC3);
        host_read(2'd1, v); check_eq("R6 slave done", v, 8'h01);
        host_read(2'd2, v); check_eq("R4 slave received byte", v, 8'h96);
        @(negedge clk); ss_n_i = 1;
        repeat (8) @(negedge clk);

        // R10 abort mid-byte, then R5 slave LSB first
        host_write(2'd0, 8'h05);
        host_write(2'd2, 8'h2D);
        slave_xfer(8'h55, 1'b1, 3, cap);
        ss_n_i = 1;
        repeat (8) @(negedge clk);
        host_read(2'd1, v); check_eq("R10 no done after abort", v, 0);
        host_read(2'd2, v); check_eq("R10 loaded byte restored", v, 8'h2D);
        slave_xfer(8'hB1, 1'b1, 8, cap);
        check_eq("R5 slave LSB first sent", cap, 8'h2D);
        host_read(2'd2, v); check_eq("R5 slave LSB first received", v, 8'hB1);
        ss_n_i = 1;
        repeat (8) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule